// File: doc/BRIEF.md
# Runtime FIR Coefficient Bus Agent

This block holds the coefficient bank of a FIR filter and puts it on a memory-mapped agent port. A host can read and rewrite coefficients while the filter keeps running. The filter side gets one flat parallel bus that carries every current coefficient. Coefficients sit in a window of word addresses that starts at a base address. Each coefficient takes as many consecutive words as its width needs.

A mode parameter sets how much of the bus is live: constant (no access), read-only, write-only or read-write. Reads are pipelined and return in order after a fixed two-cycle latency, marked by a one-cycle valid strobe. When a coefficient is split across several bus words, writes to its lower words are held until its top word arrives. The whole coefficient then changes in one cycle, so the filter never sees a value that is half new and half old. One clock and an active-high synchronous reset drive the whole block.

Top module: `fir_coef_agent`

## Requirements
- R1: Only addresses from BASE_ADDR up to BASE_ADDR + NUM_COEFS*WORDS - 1 are decoded, where WORDS = ceil(COEF_W/DATA_W). A write outside this window changes no coefficient, and a read outside it produces no valid response.
- R2: Word w of coefficient i sits at BASE_ADDR + i*WORDS + w, with w = 0 the least significant DATA_W bits. The top word carries the remaining COEF_W-(WORDS-1)*DATA_W bits: on a read it comes back zero-extended, and on a write its unused upper data bits are ignored.
- R3: In write or read-write mode, a write strobe with an in-window address and data is taken at that clock edge. A lower-word write only loads a shared holding register (cleared by reset) and leaves the coefficient bus unchanged. A top-word write updates the coefficient in one step to {top word, held lower words}.
- R4: In read or read-write mode, an in-window read strobe raises the valid output exactly two clock edges later. The read data then carries the addressed word as it was when the request was sampled.
- R5: Reads may be issued on every cycle with no wait, and the responses come back in request order, one per in-window request.
- R6: The valid output is low in every cycle that does not carry a response to an in-window read.
- R7: A cycle with read and write both high is ignored: no coefficient or holding register changes, and no response is produced.
- R8: The mode parameter is encoded as 0 constant, 1 read-only, 2 write-only, 3 read-write. In read-only mode, write strobes change nothing.
- R9: In write-only and constant modes the valid output never rises. In constant mode the coefficients never leave their initial values.
- R10: Reset reloads every coefficient from INIT_COEFS (coefficient i in bits i*COEF_W upward), clears the holding register, and drops every read still in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for bus and filter side |
| rst | input | 1 | Active-high synchronous reset |
| bus_addr | input | ADDR_W | Word address of the request |
| bus_wdata | input | DATA_W | Write data word |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Read response word, meaningful while bus_rvalid is high |
| bus_rvalid | output | 1 | Read response strobe |
| coefs_out | output | NUM_COEFS*COEF_W | All current coefficients, coefficient i in bits i*COEF_W upward |

## Verification
The bench writes every word of every coefficient. It checks that lower-word writes leave the filter bus untouched, which a design that commits each word at once would break. It sweeps back-to-back reads across the window and a few addresses on either side. A decoder with an off-by-one edge, a response out of order, or a latency other than two would each show up as a wrong word, a wrong cycle or a wrong response count. The bench also puts read and write in the same cycle, and writes to the top word with its unused bits set. It issues a read and then rewrites the same coefficient in the next cycle, so a design that sampled the bank late would return the new value. It resets with a read in flight and runs the other three modes side by side, so a response that survives reset, a write honoured in read-only or constant mode, or a stray strobe from a mode without reads would each be reported.

// File: rtl/fir_coef_agent.sv
module fir_coef_agent #(
  parameter int MODE      = 3,
  parameter int NUM_COEFS = 4,
  parameter int COEF_W    = 20,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16,
  parameter logic [NUM_COEFS*COEF_W-1:0] INIT_COEFS = '0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic                        bus_rvalid,
  output logic [NUM_COEFS*COEF_W-1:0] coefs_out
);
  localparam int WORDS  = (COEF_W + DATA_W - 1) / DATA_W;
  localparam int SPAN   = NUM_COEFS * WORDS;
  localparam int TOP_W  = COEF_W - (WORDS - 1) * DATA_W;
  localparam int IDX_W  = NUM_COEFS > 1 ? $clog2(NUM_COEFS) : 1;
  localparam int WSEL_W = WORDS > 1 ? $clog2(WORDS) : 1;
  localparam bit RD_EN  = (MODE == 1) || (MODE == 3);
  localparam bit WR_EN  = (MODE == 2) || (MODE == 3);

  logic [ADDR_W:0]       offset;
  logic                  in_win, is_top, wr_go, rd_go;
  logic [IDX_W-1:0]      idx;
  logic [WSEL_W-1:0]     wsel;
  logic [COEF_W-1:0]     coef [NUM_COEFS];
  logic [COEF_W-1:0]     new_val;
  logic [WORDS*DATA_W-1:0] padded;
  logic [DATA_W-1:0]     rd_word;

  assign offset = {1'b0, bus_addr} - {1'b0, BASE_ADDR};
  assign in_win = (bus_addr >= BASE_ADDR) && (offset < (ADDR_W+1)'(SPAN));
  assign idx    = IDX_W'(offset / (ADDR_W+1)'(WORDS));
  assign wsel   = WSEL_W'(offset % (ADDR_W+1)'(WORDS));
  assign is_top = wsel == WSEL_W'(WORDS - 1);
  assign wr_go  = WR_EN && in_win && bus_wr && !bus_rd;
  assign rd_go  = RD_EN && in_win && bus_rd && !bus_wr;

  generate
    if (WORDS > 1) begin : g_split
      logic [(WORDS-1)*DATA_W-1:0] hold;
      always_ff @(posedge clk) begin
        if (rst) hold <= '0;
        else if (wr_go && !is_top) hold[wsel*DATA_W +: DATA_W] <= bus_wdata;
      end
      assign new_val = {bus_wdata[TOP_W-1:0], hold};
    end else begin : g_single
      assign new_val = bus_wdata[TOP_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_COEFS; i++) coef[i] <= INIT_COEFS[i*COEF_W +: COEF_W];
    end else if (wr_go && is_top) begin
      coef[idx] <= new_val;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_COEFS; gi++) begin : g_out
      assign coefs_out[gi*COEF_W +: COEF_W] = coef[gi];
    end
  endgenerate

  assign padded  = (WORDS*DATA_W)'(coef[idx]);
  assign rd_word = padded[wsel*DATA_W +: DATA_W];

  generate
    if (RD_EN) begin : g_rd
      logic              p1_v, q_v;
      logic [DATA_W-1:0] p1_d, q_d;
      always_ff @(posedge clk) begin
        if (rst) begin
          p1_v <= 1'b0;
          q_v  <= 1'b0;
          p1_d <= '0;
          q_d  <= '0;
        end else begin
          p1_v <= rd_go;
          p1_d <= rd_word;
          q_v  <= p1_v;
          q_d  <= p1_d;
        end
      end
      assign bus_rvalid = q_v;
      assign bus_rdata  = q_d;

      AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> ##1 bus_rvalid); // R4
      AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
        bus_rvalid |-> $past(rd_go, 2)); // R6
    end else begin : g_nord
      assign bus_rvalid = 1'b0;
      assign bus_rdata  = '0;
    end

    if (!WR_EN) begin : g_nowr
      AST_WR_IGNORED: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> $stable(coefs_out)); // R8
    end
  endgenerate

  AST_OUTWIN_WR: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !in_win) |=> $stable(coefs_out)); // R1
  AST_LOWER_HOLD: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && in_win && !is_top) |=> $stable(coefs_out)); // R3
  AST_RDWR_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_wr) |=> $stable(coefs_out)); // R7
endmodule

// File: tb/fir_coef_agent_test.sv
module fir_coef_agent_test;
  localparam int NC = 4, CW = 20, DW = 8, AW = 8, WORDS = 3, BASE = 16, SPAN = 12;

  function automatic logic [CW-1:0] init_val(int i);
    return CW'(i * 240007 + 4660);
  endfunction
  function automatic logic [NC*CW-1:0] build_init();
    logic [NC*CW-1:0] v;
    for (int i = 0; i < NC; i++) v[i*CW +: CW] = init_val(i);
    return v;
  endfunction
  localparam logic [NC*CW-1:0] INIT = build_init();

  logic clk = 0, rst = 1, wr = 0, rd = 0;
  logic [AW-1:0] addr = 0;
  logic [DW-1:0] wdata = 0;
  logic [DW-1:0] rd_rw, rd_ro, rd_wo, rd_cn;
  logic rv_rw, rv_ro, rv_wo, rv_cn;
  logic [NC*CW-1:0] c_rw, c_ro, c_wo, c_cn;

  always #2ns clk = ~clk;

  fir_coef_agent #(.MODE(3), .NUM_COEFS(NC), .COEF_W(CW), .DATA_W(DW), .ADDR_W(AW),
    .BASE_ADDR(AW'(BASE)), .INIT_COEFS(INIT)) uut (.clk(clk), .rst(rst), .bus_addr(addr),
    .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rd_rw), .bus_rvalid(rv_rw), .coefs_out(c_rw));
  fir_coef_agent #(.MODE(1), .NUM_COEFS(NC), .COEF_W(CW), .DATA_W(DW), .ADDR_W(AW),
    .BASE_ADDR(AW'(BASE)), .INIT_COEFS(INIT)) u_ro (.clk(clk), .rst(rst), .bus_addr(addr),
    .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rd_ro), .bus_rvalid(rv_ro), .coefs_out(c_ro));
  fir_coef_agent #(.MODE(2), .NUM_COEFS(NC), .COEF_W(CW), .DATA_W(DW), .ADDR_W(AW),
    .BASE_ADDR(AW'(BASE)), .INIT_COEFS(INIT)) u_wo (.clk(clk), .rst(rst), .bus_addr(addr),
    .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rd_wo), .bus_rvalid(rv_wo), .coefs_out(c_wo));
  fir_coef_agent #(.MODE(0), .NUM_COEFS(NC), .COEF_W(CW), .DATA_W(DW), .ADDR_W(AW),
    .BASE_ADDR(AW'(BASE)), .INIT_COEFS(INIT)) u_cn (.clk(clk), .rst(rst), .bus_addr(addr),
    .bus_wdata(wdata), .bus_wr(wr), .bus_rd(rd), .bus_rdata(rd_cn), .bus_rvalid(rv_cn), .coefs_out(c_cn));

  int checks = 0, fails = 0, cyc = 0, stray = 0;
  logic [CW-1:0] m_rw [NC], m_wo [NC];
  logic [15:0] h_rw, h_wo;
  bit push_on = 1;
  int exp_rw_d[$], exp_rw_c[$], got_rw_d[$], got_rw_c[$];
  int exp_ro_d[$], exp_ro_c[$], got_ro_d[$], got_ro_c[$];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rv_rw) begin got_rw_d.push_back(int'(rd_rw)); got_rw_c.push_back(cyc); end
    if (rv_ro) begin got_ro_d.push_back(int'(rd_ro)); got_ro_c.push_back(cyc); end
    if (rv_wo || rv_cn) stray++;
  end

  task automatic check(bit ok, string req, logic [NC*CW-1:0] act, logic [NC*CW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NC*CW-1:0] pack(input logic [CW-1:0] m [NC]);
    logic [NC*CW-1:0] v;
    for (int i = 0; i < NC; i++) v[i*CW +: CW] = m[i];
    return v;
  endfunction

  function automatic int word_of(logic [CW-1:0] c, int w);
    logic [WORDS*DW-1:0] p;
    p = (WORDS*DW)'(c);
    return int'(p[w*DW +: DW]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NC; i++) begin m_rw[i] = init_val(i); m_wo[i] = init_val(i); end
    h_rw = 0; h_wo = 0;
  endtask

  task automatic drive(int a, int d, bit r, bit w);
    int off, ci, wi;
    @(negedge clk);
    addr = AW'(a); wdata = DW'(d); rd = r; wr = w;
    if (a >= BASE && a < BASE + SPAN && !(r && w)) begin
      off = a - BASE; ci = off / WORDS; wi = off % WORDS;
      if (w) begin
        if (wi < WORDS - 1) begin
          h_rw[wi*DW +: DW] = DW'(d); h_wo[wi*DW +: DW] = DW'(d);
        end else begin
          m_rw[ci] = {4'(d), h_rw}; m_wo[ci] = {4'(d), h_wo};
        end
      end else if (r && push_on) begin
        exp_rw_d.push_back(word_of(m_rw[ci], wi)); exp_rw_c.push_back(cyc + 2);
        exp_ro_d.push_back(word_of(init_val(ci), wi)); exp_ro_c.push_back(cyc + 2);
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    rd = 0; wr = 0;
  endtask

  task automatic check_coefs(string req);
    check(c_rw == pack(m_rw), {req, " rw bank"}, c_rw, pack(m_rw));
    check(c_ro == INIT, {req, " R8 ro bank"}, c_ro, INIT);
    check(c_wo == pack(m_wo), {req, " wo bank"}, c_wo, pack(m_wo));
    check(c_cn == INIT, {req, " R9 const bank"}, c_cn, INIT);
  endtask

  task automatic flush(string req);
    repeat (4) idle();
    check(got_rw_d.size() == exp_rw_d.size(), {req, " R5 rw count"}, got_rw_d.size(), exp_rw_d.size());
    check(got_ro_d.size() == exp_ro_d.size(), {req, " R5 ro count"}, got_ro_d.size(), exp_ro_d.size());
    for (int k = 0; k < exp_rw_d.size() && k < got_rw_d.size(); k++) begin
      check(got_rw_d[k] == exp_rw_d[k], {req, " R2 R5 rw data"}, got_rw_d[k], exp_rw_d[k]);
      check(got_rw_c[k] == exp_rw_c[k], {req, " R4 rw latency"}, got_rw_c[k], exp_rw_c[k]);
    end
    for (int k = 0; k < exp_ro_d.size() && k < got_ro_d.size(); k++) begin
      check(got_ro_d[k] == exp_ro_d[k], {req, " R8 ro data"}, got_ro_d[k], exp_ro_d[k]);
      check(got_ro_c[k] == exp_ro_c[k], {req, " R4 ro latency"}, got_ro_c[k], exp_ro_c[k]);
    end
    exp_rw_d.delete(); exp_rw_c.delete(); got_rw_d.delete(); got_rw_c.delete();
    exp_ro_d.delete(); exp_ro_c.delete(); got_ro_d.delete(); got_ro_c.delete();
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(4ns * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    // R10 reset state
    check_coefs("R10 reset");
    check(!rv_rw && !rv_ro, "R6 R10 no valid after reset", {rv_rw, rv_ro}, 0);

    // R1 R4 R5 R6 back-to-back sweep over the window and its edges
    for (int a = BASE - 3; a < BASE + SPAN + 3; a++) drive(a, 0, 1, 0);
    flush("R1 sweep");

    // R3 lower words do not reach the filter
    drive(BASE + 6, 8'hA1, 0, 1); idle(); check_coefs("R3 lower word 0");
    drive(BASE + 7, 8'hB2, 0, 1); idle(); check_coefs("R3 lower word 1");
    // R2 top word with unused bits set
    drive(BASE + 8, 8'hF5, 0, 1); idle(); check_coefs("R2 R3 top commit");
    drive(BASE + 8, 0, 1, 0); flush("R2 top zero-extend");

    // R1 out-of-window writes
    drive(BASE - 1, 8'h77, 0, 1); drive(BASE + SPAN, 8'h77, 0, 1); drive(255, 8'h77, 0, 1);
    idle(); check_coefs("R1 outside writes");

    // R7 read and write together on a top word
    drive(BASE + 2, 8'h0C, 1, 1); idle(); check_coefs("R7 rd+wr frozen");
    drive(BASE + 3, 8'h11, 1, 1); drive(BASE + 5, 8'h0E, 0, 1); idle();
    check_coefs("R7 hold unchanged");
    flush("R7 no response");

    // R3 every word of every coefficient
    for (int i = 0; i < NC; i++) begin
      for (int w = 0; w < WORDS; w++) drive(BASE + i*WORDS + w, (i*37 + w*91 + 5) & 255, 0, 1);
      idle(); check_coefs("R3 full coefficient write");
    end
    for (int a = BASE + SPAN - 1; a >= BASE - 1; a--) drive(a, 0, 1, 0);
    flush("R5 reverse sweep");

    // R4 read sees the value at request even if rewritten next cycle
    drive(BASE + 4, 0, 1, 0); drive(BASE + 5, 8'h03, 0, 1);
    flush("R4 read before rewrite");
    idle(); check_coefs("R3 rewrite after read");

    // R10 reset with a read in flight
    push_on = 0;
    drive(BASE + 1, 0, 1, 0);
    @(negedge clk); rd = 0; rst = 1;
    @(negedge clk); rst = 0;
    push_on = 1;
    model_reset();
    flush("R10 dropped read");
    check_coefs("R10 reload");
    drive(BASE + 8, 8'h09, 0, 1); idle(); check_coefs("R10 hold cleared");

    check(stray == 0, "R9 no valid in write-only or constant", stray, 0);
    summary();
  end
endmodule